// File: doc/BRIEF.md
# UART Receive Queue with Status Flags

This block is the receive-side character buffer of a serial port. A deserializer hands it 12-bit words: the low 8 bits carry the character and the upper 4 bits carry per-character error indications. The words go into a 16-slot circular store. A CPU-facing read port sees them in arrival order. A line-break event enters the same queue as a special word.

The block keeps an empty flag, a full flag, an occupancy count and a receive interrupt level that rises when the fill reaches a trigger of one. It also keeps a 4-bit receive status register that captures the error bits of each popped word. A configuration write picks between queue mode, which holds up to 16 words, and holding mode, which holds one word. Any change of that mode discards the stored words. A push that finds no room is dropped and raises a sticky overflow indication.

The flags are registers driven by events, not decodes of the count. A flush therefore moves the count and the read position but leaves the empty, full and interrupt outputs where they were until the next push or pop.

Top module: `uart_rx_queue`

## Requirements
- R1: After synchronous reset, count_o is 0, empty_o is 1, full_o is 0, irq_o is 0, rx_status_o is 0, overflow_o is 0, and the block is in holding mode.
- R2: In queue mode (cfg_fifo_en_i written as 1), the block accepts pushes while the count is below 16. Words are popped in push order. rd_word_o always shows the word at the read position. The read and write positions wrap modulo 16, and the write slot is the read position plus the count.
- R3: In holding mode (cfg_fifo_en_i written as 0), a push is accepted only while the count is 0, and every accepted push sets full_o.
- R4: In queue mode, full_o sets when an accepted push brings the count to 16. Every pop clears full_o, including a pop at count 0.
- R5: An accepted push clears empty_o. A pop that leaves the count at 0 sets empty_o.
- R6: irq_o sets when an accepted push makes the count equal 1. It clears when a pop leaves the count at 0. A flush does not change it.
- R7: A pop loads rx_status_o with bits 11:8 of the word shown on rd_word_o in that cycle. Asserting sts_clr_i without a pop clears rx_status_o. When both are asserted, the pop load wins.
- R8: rx_break_i pushes the word 0x400 (bit 10 set, data bits zero). If rx_push_i is asserted in the same cycle, the data word is discarded and does not count as an overflow.
- R9: A cfg_wr_i whose cfg_fifo_en_i value differs from the current mode sets the count and the read position to 0. A cfg_wr_i with the same value changes nothing. Neither case changes empty_o, full_o or irq_o.
- R10: A pop at count 0 leaves the count and the read position unchanged, so rd_word_o keeps showing the same stale slot. It still sets empty_o and loads rx_status_o.
- R11: A push (data or break) that finds no room is dropped. It sets overflow_o, which stays set until reset.
- R12: Within one cycle the pop is applied first, then the mode write, then the push. A push to a full queue accompanied by a pop is therefore accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_push_i | input | 1 | Push strobe for a received word |
| rx_word_i | input | 12 | Received word: error bits 11:8, data 7:0 |
| rx_break_i | input | 1 | Line-break strobe, pushes 0x400 |
| rd_pop_i | input | 1 | CPU data read strobe |
| rd_word_o | output | 12 | Word at the current read position |
| cfg_wr_i | input | 1 | Mode write strobe |
| cfg_fifo_en_i | input | 1 | Mode value: 1 queue, 0 holding |
| sts_clr_i | input | 1 | Clear strobe for the receive status |
| rx_status_o | output | 4 | Error bits of the last popped word |
| count_o | output | 5 | Stored word count |
| empty_o | output | 1 | Empty flag |
| full_o | output | 1 | Full flag |
| irq_o | output | 1 | Receive interrupt level |
| overflow_o | output | 1 | Sticky dropped-push indication |

## Verification
The hardest state to reach is a pop at count 0 with the read position away from slot 0. This corner shows whether the block returns the stale slot without moving. The stimulus fills all 16 slots in queue mode and drains three. It refills across the wrap and then drains completely, which leaves the read position at 3 and the old contents visible. A second hard corner is a flush while words and an active interrupt are present. The stimulus follows the flush with a pop at count 0 and checks that the flags change only on that pop.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
    localparam int unsigned RXQ_DEPTH  = 16;
    localparam int unsigned WORD_W     = 12;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned TRIG_LVL   = 1;
    localparam int unsigned BRK_BIT    = 10;
    localparam int unsigned POS_W      = $clog2(RXQ_DEPTH);
    localparam int unsigned CNT_W      = $clog2(RXQ_DEPTH + 1);
    localparam int unsigned STS_W      = WORD_W - DATA_W;

    typedef logic [WORD_W-1:0] rx_word_t;
    typedef logic [POS_W-1:0]  rx_pos_t;
    typedef logic [CNT_W-1:0]  rx_cnt_t;
    typedef logic [STS_W-1:0]  rx_sts_t;

    typedef struct packed {
        rx_cnt_t cnt;
        rx_pos_t pos;
        logic    fifo_en;
        logic    empty;
        logic    full;
        logic    irq;
        logic    ovf;
    } rxq_state_t;

    localparam rx_word_t BRK_WORD = rx_word_t'(1) << BRK_BIT;

    // Depth is a power of two, so truncation gives the modulo wrap.
    function automatic rx_pos_t slot_of(rx_pos_t pos, rx_cnt_t cnt);
        return rx_pos_t'(pos + rx_pos_t'(cnt));
    endfunction

    function automatic rx_cnt_t cap_of(logic fifo_en);
        return fifo_en ? rx_cnt_t'(RXQ_DEPTH) : rx_cnt_t'(1);
    endfunction
endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
    import uart_rxq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en_i,
    input  rx_pos_t  wr_slot_i,
    input  rx_word_t wr_word_i,
    input  rx_pos_t  rd_pos_i,
    output rx_word_t rd_word_o
);
    rx_word_t mem [RXQ_DEPTH];

    for (genvar i = 0; i < RXQ_DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (wr_en_i && wr_slot_i == rx_pos_t'(i))
                mem[i] <= wr_word_i;
        end
    end

    assign rd_word_o = mem[rd_pos_i];
endmodule

// File: rtl/uart_rxq_status.sv
module uart_rxq_status
    import uart_rxq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_i,
    input  logic     clr_i,
    input  rx_word_t word_i,
    output rx_sts_t  sts_o
);
    always_ff @(posedge clk) begin
        if (rst)
            sts_o <= '0;
        else if (load_i)
            sts_o <= word_i[WORD_W-1:DATA_W];
        else if (clr_i)
            sts_o <= '0;
    end
endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl
    import uart_rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pop_i,
    input  logic       push_i,
    input  logic       brk_i,
    input  rx_word_t   push_word_i,
    input  logic       cfg_wr_i,
    input  logic       cfg_fifo_en_i,
    output rxq_state_t state_o,
    output logic       wr_en_o,
    output rx_pos_t    wr_slot_o,
    output rx_word_t   wr_word_o
);
    rxq_state_t cur, nxt;
    logic       any_push;

    assign any_push  = push_i | brk_i;
    assign wr_word_o = brk_i ? BRK_WORD : push_word_i;

    always_comb begin
        nxt       = cur;
        wr_en_o   = 1'b0;
        wr_slot_o = '0;
        // step 1: pop
        if (pop_i) begin
            nxt.full = 1'b0;
            if (nxt.cnt != '0) begin
                nxt.cnt = nxt.cnt - rx_cnt_t'(1);
                nxt.pos = nxt.pos + rx_pos_t'(1);
            end
            if (nxt.cnt == '0)
                nxt.empty = 1'b1;
            if (nxt.cnt == rx_cnt_t'(TRIG_LVL - 1))
                nxt.irq = 1'b0;
        end
        // step 2: mode write, flush on change
        if (cfg_wr_i) begin
            if (cfg_fifo_en_i != nxt.fifo_en) begin
                nxt.cnt = '0;
                nxt.pos = '0;
            end
            nxt.fifo_en = cfg_fifo_en_i;
        end
        // step 3: push
        if (any_push) begin
            if (nxt.cnt < cap_of(nxt.fifo_en)) begin
                wr_en_o   = 1'b1;
                wr_slot_o = slot_of(nxt.pos, nxt.cnt);
                nxt.cnt   = nxt.cnt + rx_cnt_t'(1);
                nxt.empty = 1'b0;
                if (!nxt.fifo_en || nxt.cnt == rx_cnt_t'(RXQ_DEPTH))
                    nxt.full = 1'b1;
                if (nxt.cnt == rx_cnt_t'(TRIG_LVL))
                    nxt.irq = 1'b1;
            end else begin
                nxt.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur         <= '0;
            cur.empty   <= 1'b1;
        end else begin
            cur <= nxt;
        end
    end

    assign state_o = cur;
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_rxq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_push_i,
    input  logic [WORD_W-1:0]   rx_word_i,
    input  logic                rx_break_i,
    input  logic                rd_pop_i,
    output logic [WORD_W-1:0]   rd_word_o,
    input  logic                cfg_wr_i,
    input  logic                cfg_fifo_en_i,
    input  logic                sts_clr_i,
    output logic [STS_W-1:0]    rx_status_o,
    output logic [CNT_W-1:0]    count_o,
    output logic                empty_o,
    output logic                full_o,
    output logic                irq_o,
    output logic                overflow_o
);
    rxq_state_t st;
    logic       wr_en;
    rx_pos_t    wr_slot;
    rx_word_t   wr_word;
    rx_word_t   head_word;

    uart_rxq_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .pop_i         (rd_pop_i),
        .push_i        (rx_push_i),
        .brk_i         (rx_break_i),
        .push_word_i   (rx_word_i),
        .cfg_wr_i      (cfg_wr_i),
        .cfg_fifo_en_i (cfg_fifo_en_i),
        .state_o       (st),
        .wr_en_o       (wr_en),
        .wr_slot_o     (wr_slot),
        .wr_word_o     (wr_word)
    );

    uart_rxq_store u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_slot_i (wr_slot),
        .wr_word_i (wr_word),
        .rd_pos_i  (st.pos),
        .rd_word_o (head_word)
    );

    uart_rxq_status u_status (
        .clk    (clk),
        .rst    (rst),
        .load_i (rd_pop_i),
        .clr_i  (sts_clr_i),
        .word_i (head_word),
        .sts_o  (rx_status_o)
    );

    assign rd_word_o  = head_word;
    assign count_o    = st.cnt;
    assign empty_o    = st.empty;
    assign full_o     = st.full;
    assign irq_o      = st.irq;
    assign overflow_o = st.ovf;
endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk
    import uart_rxq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rx_push_i,
    input logic              rx_break_i,
    input logic              rd_pop_i,
    input logic              cfg_wr_i,
    input logic              sts_clr_i,
    input logic              fifo_en,
    input logic [CNT_W-1:0]  count_o,
    input logic [STS_W-1:0]  rx_status_o,
    input logic              empty_o,
    input logic              irq_o,
    input logic              overflow_o
);
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count_o <= CNT_W'(RXQ_DEPTH));

    assert_hold_depth_R3: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> count_o <= CNT_W'(1));

    assert_pop_step_R2: assert property (@(posedge clk) disable iff (rst)
        rd_pop_i && !rx_push_i && !rx_break_i && !cfg_wr_i && count_o != '0
        |=> count_o == $past(count_o) - CNT_W'(1));

    assert_first_push_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_push_i || rx_break_i) && !rd_pop_i && !cfg_wr_i && count_o == '0
        |=> irq_o && !empty_o);

    assert_sts_clear_R7: assert property (@(posedge clk) disable iff (rst)
        sts_clr_i && !rd_pop_i |=> rx_status_o == '0);

    assert_full_drop_R11: assert property (@(posedge clk) disable iff (rst)
        rx_push_i && fifo_en && !rd_pop_i && !cfg_wr_i && count_o == CNT_W'(RXQ_DEPTH)
        |=> overflow_o && count_o == CNT_W'(RXQ_DEPTH));

    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o);
endmodule

bind uart_rx_queue uart_rx_queue_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_push_i   (rx_push_i),
    .rx_break_i  (rx_break_i),
    .rd_pop_i    (rd_pop_i),
    .cfg_wr_i    (cfg_wr_i),
    .sts_clr_i   (sts_clr_i),
    .fifo_en     (st.fifo_en),
    .count_o     (count_o),
    .rx_status_o (rx_status_o),
    .empty_o     (empty_o),
    .irq_o       (irq_o),
    .overflow_o  (overflow_o)
);

// File: tb/uart_rx_queue_tb.sv
module uart_rx_queue_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_push_i = 0, rx_break_i = 0, rd_pop_i = 0;
    logic        cfg_wr_i = 0, cfg_fifo_en_i = 0, sts_clr_i = 0;
    logic [11:0] rx_word_i = '0;
    logic [11:0] rd_word_o;
    logic [3:0]  rx_status_o;
    logic [4:0]  count_o;
    logic        empty_o, full_o, irq_o, overflow_o;

    int tests = 0, fails = 0;

    // reference state
    logic [11:0] exp_q[$];
    logic [11:0] m_slot [16];
    int          m_pos = 0;
    logic        m_fen = 0, m_empty = 1, m_full = 0, m_irq = 0, m_ovf = 0;
    logic [3:0]  m_sts = '0;

    always #4 clk = ~clk;

    uart_rx_queue u_dut (
        .clk(clk), .rst(rst), .rx_push_i(rx_push_i), .rx_word_i(rx_word_i),
        .rx_break_i(rx_break_i), .rd_pop_i(rd_pop_i), .rd_word_o(rd_word_o),
        .cfg_wr_i(cfg_wr_i), .cfg_fifo_en_i(cfg_fifo_en_i), .sts_clr_i(sts_clr_i),
        .rx_status_o(rx_status_o), .count_o(count_o), .empty_o(empty_o),
        .full_o(full_o), .irq_o(irq_o), .overflow_o(overflow_o)
    );

    task automatic chk(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // One cycle: drive at negedge, check next negedge.
    task automatic cycle(bit push, logic [11:0] w, bit brk, bit pop, bit clr,
                         bit cw, bit cv, string tag);
        logic [11:0] popped;
        int          sz;
        rx_push_i = push; rx_word_i = w; rx_break_i = brk; rd_pop_i = pop;
        sts_clr_i = clr; cfg_wr_i = cw; cfg_fifo_en_i = cv;
        #1;
        // scoreboard monitor: the popped word is the head of the queue
        if (pop) begin
            popped = m_slot[m_pos];
            if (exp_q.size() > 0) popped = exp_q[0];
            chk(tag, "popped word", int'(rd_word_o), int'(popped));
            m_full = 0;
            if (exp_q.size() > 0) begin
                void'(exp_q.pop_front());
                m_pos = (m_pos + 1) % 16;
            end
            if (exp_q.size() == 0) begin m_empty = 1; m_irq = 0; end
            m_sts = popped[11:8];
        end else if (clr) m_sts = '0;
        if (cw) begin
            if (cv != m_fen) begin exp_q.delete(); m_pos = 0; end
            m_fen = cv;
        end
        if (push || brk) begin
            sz = exp_q.size();
            if (sz < (m_fen ? 16 : 1)) begin
                m_slot[(m_pos + sz) % 16] = brk ? 12'h400 : w;
                exp_q.push_back(brk ? 12'h400 : w);
                m_empty = 0;
                if (!m_fen || exp_q.size() == 16) m_full = 1;
                if (exp_q.size() == 1) m_irq = 1;
            end else m_ovf = 1;
        end
        @(posedge clk);
        @(negedge clk);
        rx_push_i = 0; rx_break_i = 0; rd_pop_i = 0; sts_clr_i = 0; cfg_wr_i = 0;
        chk(tag, "count", int'(count_o), exp_q.size());
        chk("R5", "empty", int'(empty_o), int'(m_empty));
        chk("R4", "full", int'(full_o), int'(m_full));
        chk("R6", "irq", int'(irq_o), int'(m_irq));
        chk("R7", "status", int'(rx_status_o), int'(m_sts));
        chk("R11", "overflow", int'(overflow_o), int'(m_ovf));
        if (exp_q.size() > 0)
            chk(tag, "head word", int'(rd_word_o), int'(exp_q[0]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (all requirements)");
        summary();
    end

    initial begin
        for (int i = 0; i < 16; i++) m_slot[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", "count", int'(count_o), 0);
        chk("R1", "empty", int'(empty_o), 1);
        chk("R1", "full", int'(full_o), 0);
        chk("R1", "irq", int'(irq_o), 0);
        chk("R1", "status", int'(rx_status_o), 0);
        chk("R1", "overflow", int'(overflow_o), 0);

        // R8 break beats a data push, no overflow
        cycle(1, 12'h0AB, 1, 0, 0, 0, 0, "R8");
        cycle(0, 12'h000, 0, 1, 0, 0, 0, "R8");
        // R3 holding mode
        cycle(1, 12'h3C5, 0, 0, 0, 0, 0, "R3");
        cycle(1, 12'h155, 0, 0, 0, 0, 0, "R11");
        cycle(0, 12'h000, 0, 1, 0, 0, 0, "R3");
        cycle(0, 12'h000, 0, 0, 1, 0, 0, "R7");
        // R9 switch to queue mode
        cycle(0, 12'h000, 0, 0, 0, 1, 1, "R9");
        for (int i = 0; i < 16; i++)
            cycle(1, 12'(i * 12'h111 ^ 12'h05A), 0, 0, 0, 0, 0, "R2");
        cycle(1, 12'h777, 0, 0, 0, 0, 0, "R11");
        cycle(1, 12'h9E1, 0, 1, 0, 0, 0, "R12");
        for (int i = 0; i < 3; i++) cycle(0, 12'h000, 0, 1, 0, 0, 0, "R2");
        for (int i = 0; i < 2; i++) cycle(1, 12'(12'h2A0 + i), 0, 0, 0, 0, 0, "R2");
        while (exp_q.size() > 0) cycle(0, 12'h000, 0, 1, 0, 0, 0, "R2");
        // R10 pop at count 0 with read position away from slot 0
        cycle(0, 12'h000, 0, 1, 0, 0, 0, "R10");
        cycle(0, 12'h000, 0, 1, 1, 0, 0, "R10");
        cycle(0, 12'h000, 0, 0, 1, 0, 0, "R7");
        // R9 same-mode write keeps words, mode change flushes, flags hold
        cycle(1, 12'hB12, 0, 0, 0, 0, 0, "R5");
        cycle(1, 12'h634, 0, 0, 0, 0, 0, "R2");
        cycle(0, 12'h000, 0, 0, 0, 1, 1, "R9");
        cycle(0, 12'h000, 0, 0, 0, 1, 0, "R9");
        cycle(0, 12'h000, 0, 1, 0, 0, 0, "R10");
        cycle(1, 12'h0C3, 0, 0, 0, 0, 0, "R6");
        cycle(1, 12'h0C4, 0, 1, 0, 0, 0, "R12");
        summary();
    end
endmodule